// File: doc/BRIEF.md
# Byte Transfer Sequencer with Stretchable Hold

The sequencer sits between software-visible controls and a bit-level serial bus engine. It owns a 16-byte FIFO, a down-counter for bytes still to receive and the decision at the end of each burst: release the bus with a stop, or keep it stretched so that software can refill the FIFO, reload the counter or issue a repeated start. Software sets the direction, the addressing width and the hold flag as levels. Writing the target address launches a transfer.

In transmit mode the engine drains the FIFO through a valid/ready byte handshake. In receive mode the engine offers bytes and the sequencer accepts them while bytes remain to be counted and the FIFO has room. When the FIFO fills during a receive, the sequencer stretches the bus rather than losing the byte. Events are one-cycle pulses that appear on the clock edge after their cause: completion, the receive fill reaching two below full, the overflows, the underflow and an aborted transfer.

Top module: `bseq_top`

## Requirements
- R1: After reset the bus is idle, the FIFO is empty, the size view reads 0 and every event, start and stop output is low.
- R2: The FIFO keeps 16 bytes in arrival order. `sw_rdata` shows the oldest byte, or 0 when empty. Software pushes take effect only in transmit mode (`cfg_rx`=0) and software pops only in receive mode (`cfg_rx`=1). Otherwise they leave the fill level unchanged.
- R3: A software push into a full FIFO in transmit mode is dropped and pulses `evt_tx_ovf` on the next cycle.
- R4: A software pop from an empty FIFO in receive mode returns 0 and pulses `evt_rx_unf` on the next cycle.
- R5: An address write with `cfg_master`=1, made while idle or paused, pulses `eng_start` one cycle later. With `cfg_short_addr`=1, `eng_addr` carries bits [6:0] zero-extended and `eng_ten`=0. Otherwise it carries bits [9:0] and `eng_ten`=1. The write is ignored while running or when `cfg_master`=0.
- R6: While running in transmit mode, the head byte is offered on `eng_tx_data` and is removed on each valid/ready handshake. When the FIFO is empty and `cfg_hold`=0, the block pulses `eng_stop` and `evt_done` and returns to idle.
- R7: When a burst ends with `cfg_hold`=1 (transmit FIFO empty, or receive count zero), `evt_done` pulses with no stop and the block pauses with `eng_stretch` high. New transmit data or a nonzero reloaded count resumes the burst. Clearing hold while paused pulses `eng_stop`.
- R8: In receive mode a byte is accepted only while the count is nonzero and the FIFO is not full, and each accepted byte lowers the count by one. A size write loads the count and takes priority over a decrement. `size_view` shows the count in receive mode and the FIFO fill level in transmit mode.
- R9: A byte offered while running in receive mode with a nonzero count and a full FIFO is not accepted, pulses `evt_rx_ovf` and holds `eng_stretch` high.
- R10: `evt_thresh` pulses once when the fill level in receive mode rises from below 14 to 14 or more.
- R11: `eng_nack` while running aborts the transfer: `evt_nack` and `eng_stop` pulse and the block returns to idle.
- R12: `rx_data_valid` is high in receive mode whenever the FIFO holds data. `bus_active` is high while running or paused.
- R13: `sw_fifo_clr` empties the FIFO on the next edge and overrides any push or pop in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx | input | 1 | Direction: 1 receive, 0 transmit |
| cfg_master | input | 1 | Address writes launch transfers when high |
| cfg_short_addr | input | 1 | 7-bit addressing when high, 10-bit when low |
| cfg_ack_en | input | 1 | Acknowledge enable passed to the engine |
| cfg_hold | input | 1 | Stretch instead of stopping at burst end |
| sw_fifo_clr | input | 1 | Empty the FIFO |
| sw_size_wr | input | 1 | Load the receive count |
| sw_size_val | input | 8 | Count value |
| sw_addr_wr | input | 1 | Address write, launches a transfer |
| sw_addr_val | input | 10 | Target address |
| sw_push | input | 1 | Software byte push |
| sw_wdata | input | 8 | Byte to push |
| sw_pop | input | 1 | Software byte pop |
| sw_rdata | output | 8 | Oldest FIFO byte, 0 when empty |
| size_view | output | 8 | Count (receive) or fill level (transmit) |
| rx_data_valid | output | 1 | Received data available |
| bus_active | output | 1 | Transfer running or paused |
| evt_done | output | 1 | Burst complete pulse |
| evt_thresh | output | 1 | Receive fill reached 14 pulse |
| evt_tx_ovf | output | 1 | Push into full FIFO pulse |
| evt_rx_ovf | output | 1 | Byte refused on full FIFO pulse |
| evt_rx_unf | output | 1 | Pop from empty FIFO pulse |
| evt_nack | output | 1 | Transfer aborted pulse |
| eng_start | output | 1 | Start (or repeated start) request |
| eng_stop | output | 1 | Stop request |
| eng_stretch | output | 1 | Keep the bus clock stretched |
| eng_addr | output | 10 | Latched target address |
| eng_ten | output | 1 | 10-bit address in use |
| eng_read | output | 1 | Transfer is a read |
| eng_ack_en | output | 1 | Acknowledge enable |
| eng_tx_valid | output | 1 | Transmit byte valid |
| eng_tx_data | output | 8 | Transmit byte |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Sequencer accepts the received byte |
| eng_nack | input | 1 | Target did not acknowledge |

## Verification
Two collisions get the most attention. In the first, a software pop lands in the cycle in which a received byte arrives at a fill of 13: the level stays at 13, so no threshold pulse may appear. In the second, a software push coincides with an engine handshake in transmit mode: the level must stay flat while the byte order is kept. Both cases come out of the bench driving the FIFO continuously from both sides while a queue-based model predicts every output each cycle, so any lost byte, duplicated byte or extra pulse shows up as a mismatch in that cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bseq_fifo.sv
module bseq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              do_push, do_pop;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign level   = lvl_q;
  assign rdata   = empty ? '0 : mem[rd_q];
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !clr));
endmodule

// File: rtl/bseq_sizecnt.sv
module bseq_sizecnt #(
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_val,
  input  logic              dec,
  output logic [SIZE_W-1:0] cnt,
  output logic              zero
);
  logic [SIZE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int THR_GAP = 2,
  parameter int SIZE_W  = 8,
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_rx,
  input  logic                       cfg_master,
  input  logic                       cfg_short_addr,
  input  logic                       cfg_hold,
  input  logic                       sw_fifo_clr,
  input  logic                       sw_size_wr,
  input  logic                       sw_addr_wr,
  input  logic [ADDR_W-1:0]          sw_addr_val,
  input  logic                       sw_push,
  input  logic                       sw_pop,
  input  logic                       eng_tx_ready,
  input  logic                       eng_rx_valid,
  input  logic                       eng_nack,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       full,
  input  logic                       empty,
  input  logic [SIZE_W-1:0]          cnt,
  input  logic                       cnt_zero,
  output logic                       fifo_clr,
  output logic                       fifo_push,
  output logic                       fifo_pop,
  output logic                       cnt_dec,
  output logic                       bus_active,
  output logic                       eng_tx_valid,
  output logic                       eng_rx_ready,
  output logic                       eng_stretch,
  output logic                       eng_start,
  output logic                       eng_stop,
  output logic [ADDR_W-1:0]          eng_addr,
  output logic                       eng_ten,
  output logic                       eng_read,
  output logic                       evt_done,
  output logic                       evt_thresh,
  output logic                       evt_tx_ovf,
  output logic                       evt_rx_ovf,
  output logic                       evt_rx_unf,
  output logic                       evt_nack
);
  localparam int LVL_W  = $clog2(DEPTH+1);
  localparam int THRESH = DEPTH - THR_GAP;

  seq_state_e st_q, st_d;
  logic tx_mode, running, start_req;
  logic push_sw, pop_sw, tx_fire, rx_fire, rx_block;
  logic tx_ovf_d, rx_unf_d, rx_ovf_d, thresh_d;
  logic start_d, stop_d, done_d, nack_d;
  logic [LVL_W:0]    lvl_nxt;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ten_q, ten_d, read_q, read_d;
  logic start_q, stop_q, done_q, nack_q, thresh_q, tx_ovf_q, rx_ovf_q, rx_unf_q;

  assign tx_mode   = !cfg_rx;
  assign running   = (st_q == ST_RUN);
  assign start_req = sw_addr_wr && cfg_master;

  // handshakes and FIFO side effects
  always_comb begin
    push_sw   = sw_push && tx_mode && !full;
    tx_ovf_d  = sw_push && tx_mode && full;
    pop_sw    = sw_pop && cfg_rx && !empty;
    rx_unf_d  = sw_pop && cfg_rx && empty;
    eng_tx_valid = running && tx_mode && !empty;
    tx_fire   = eng_tx_valid && eng_tx_ready;
    eng_rx_ready = running && cfg_rx && !cnt_zero && !full;
    rx_fire   = eng_rx_ready && eng_rx_valid;
    rx_block  = running && cfg_rx && !cnt_zero && full;
    rx_ovf_d  = rx_block && eng_rx_valid;
    fifo_clr  = sw_fifo_clr;
    fifo_push = !sw_fifo_clr && (push_sw || rx_fire);
    fifo_pop  = !sw_fifo_clr && (pop_sw || tx_fire);
    cnt_dec   = rx_fire;
    if (sw_fifo_clr) lvl_nxt = '0;
    else lvl_nxt = {1'b0, level} + (LVL_W+1)'(fifo_push) - (LVL_W+1)'(fifo_pop);
    thresh_d  = cfg_rx && ({1'b0, level} < (LVL_W+1)'(THRESH)) &&
                (lvl_nxt >= (LVL_W+1)'(THRESH));
  end

  // sequencing state machine
  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    done_d  = 1'b0;
    nack_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_req) begin
          st_d    = ST_RUN;
          start_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (eng_nack) begin
          st_d   = ST_IDLE;
          stop_d = 1'b1;
          nack_d = 1'b1;
        end else if (tx_mode ? empty : cnt_zero) begin
          done_d = 1'b1;
          if (cfg_hold) begin
            st_d = ST_PAUSE;
          end else begin
            st_d   = ST_IDLE;
            stop_d = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        if (start_req) begin
          st_d    = ST_RUN;
          start_d = 1'b1;
        end else if (!cfg_hold) begin
          st_d   = ST_IDLE;
          stop_d = 1'b1;
        end else if (tx_mode ? !empty : !cnt_zero) begin
          st_d = ST_RUN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // address latch, taken only with a start
  always_comb begin
    addr_d = addr_q;
    ten_d  = ten_q;
    read_d = read_q;
    if (start_d) begin
      addr_d = cfg_short_addr ? ADDR_W'(sw_addr_val[SHORT_W-1:0]) : sw_addr_val;
      ten_d  = !cfg_short_addr;
      read_d = cfg_rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      ten_q    <= 1'b0;
      read_q   <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      done_q   <= 1'b0;
      nack_q   <= 1'b0;
      thresh_q <= 1'b0;
      tx_ovf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      addr_q   <= addr_d;
      ten_q    <= ten_d;
      read_q   <= read_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
      done_q   <= done_d;
      nack_q   <= nack_d;
      thresh_q <= thresh_d;
      tx_ovf_q <= tx_ovf_d;
      rx_ovf_q <= rx_ovf_d;
      rx_unf_q <= rx_unf_d;
    end
  end

  assign bus_active  = (st_q != ST_IDLE);
  assign eng_stretch = (st_q == ST_PAUSE) || rx_block;
  assign eng_start   = start_q;
  assign eng_stop    = stop_q;
  assign eng_addr    = addr_q;
  assign eng_ten     = ten_q;
  assign eng_read    = read_q;
  assign evt_done    = done_q;
  assign evt_thresh  = thresh_q;
  assign evt_tx_ovf  = tx_ovf_q;
  assign evt_rx_ovf  = rx_ovf_q;
  assign evt_rx_unf  = rx_unf_q;
  assign evt_nack    = nack_q;

  // count falls by exactly one per accepted byte unless reloaded
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !sw_size_wr) |=> (cnt == $past(cnt) - 1'b1));

  assert_rx_ovf_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_ovf |-> $past(full));

  assert_thresh_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_thresh && !$past(sw_fifo_clr)) |-> (level >= LVL_W'(THRESH)));

  assert_nack_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_nack |-> (eng_stop && !bus_active));
endmodule

// File: rtl/bseq_top.sv
module bseq_top #(
  parameter int DEPTH   = 16,
  parameter int THR_GAP = 2,
  parameter int DATA_W  = 8,
  parameter int SIZE_W  = 8,
  parameter int ADDR_W  = 10,
  parameter int SHORT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx,
  input  logic              cfg_master,
  input  logic              cfg_short_addr,
  input  logic              cfg_ack_en,
  input  logic              cfg_hold,
  input  logic              sw_fifo_clr,
  input  logic              sw_size_wr,
  input  logic [SIZE_W-1:0] sw_size_val,
  input  logic              sw_addr_wr,
  input  logic [ADDR_W-1:0] sw_addr_val,
  input  logic              sw_push,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_pop,
  output logic [DATA_W-1:0] sw_rdata,
  output logic [SIZE_W-1:0] size_view,
  output logic              rx_data_valid,
  output logic              bus_active,
  output logic              evt_done,
  output logic              evt_thresh,
  output logic              evt_tx_ovf,
  output logic              evt_rx_ovf,
  output logic              evt_rx_unf,
  output logic              evt_nack,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              eng_stretch,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              eng_ten,
  output logic              eng_read,
  output logic              eng_ack_en,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              eng_rx_ready,
  input  logic              eng_nack
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic              f_clr, f_push, f_pop, f_full, f_empty;
  logic [LVL_W-1:0]  f_level;
  logic [DATA_W-1:0] f_wdata, f_rdata;
  logic [SIZE_W-1:0] cnt;
  logic              cnt_zero, cnt_dec;

  assign f_wdata = cfg_rx ? eng_rx_data : sw_wdata;

  bseq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(f_clr), .push(f_push), .pop(f_pop),
    .wdata(f_wdata), .rdata(f_rdata), .level(f_level),
    .full(f_full), .empty(f_empty)
  );

  bseq_sizecnt #(.SIZE_W(SIZE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(sw_size_wr), .load_val(sw_size_val),
    .dec(cnt_dec), .cnt(cnt), .zero(cnt_zero)
  );

  bseq_ctrl #(
    .DEPTH(DEPTH), .THR_GAP(THR_GAP), .SIZE_W(SIZE_W),
    .ADDR_W(ADDR_W), .SHORT_W(SHORT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_rx(cfg_rx), .cfg_master(cfg_master), .cfg_short_addr(cfg_short_addr),
    .cfg_hold(cfg_hold), .sw_fifo_clr(sw_fifo_clr), .sw_size_wr(sw_size_wr),
    .sw_addr_wr(sw_addr_wr), .sw_addr_val(sw_addr_val),
    .sw_push(sw_push), .sw_pop(sw_pop),
    .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid), .eng_nack(eng_nack),
    .level(f_level), .full(f_full), .empty(f_empty),
    .cnt(cnt), .cnt_zero(cnt_zero),
    .fifo_clr(f_clr), .fifo_push(f_push), .fifo_pop(f_pop), .cnt_dec(cnt_dec),
    .bus_active(bus_active), .eng_tx_valid(eng_tx_valid),
    .eng_rx_ready(eng_rx_ready), .eng_stretch(eng_stretch),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_addr(eng_addr),
    .eng_ten(eng_ten), .eng_read(eng_read),
    .evt_done(evt_done), .evt_thresh(evt_thresh), .evt_tx_ovf(evt_tx_ovf),
    .evt_rx_ovf(evt_rx_ovf), .evt_rx_unf(evt_rx_unf), .evt_nack(evt_nack)
  );

  assign sw_rdata      = f_rdata;
  assign eng_tx_data   = f_rdata;
  assign eng_ack_en    = cfg_ack_en;
  assign rx_data_valid = cfg_rx && !f_empty;
  assign size_view     = cfg_rx ? cnt : SIZE_W'(f_level);
endmodule

// File: tb/bseq_top_bench.sv
module bseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int THRESH = 14;

  logic clk, rst_n;
  logic cfg_rx, cfg_master, cfg_short_addr, cfg_ack_en, cfg_hold;
  logic sw_fifo_clr, sw_size_wr, sw_addr_wr, sw_push, sw_pop;
  logic [7:0] sw_size_val, sw_wdata, sw_rdata, size_view;
  logic [9:0] sw_addr_val, eng_addr;
  logic rx_data_valid, bus_active;
  logic evt_done, evt_thresh, evt_tx_ovf, evt_rx_ovf, evt_rx_unf, evt_nack;
  logic eng_start, eng_stop, eng_stretch, eng_ten, eng_read, eng_ack_en;
  logic eng_tx_valid, eng_tx_ready, eng_rx_valid, eng_rx_ready, eng_nack;
  logic [7:0] eng_tx_data, eng_rx_data;

  bseq_top u_bseq_top (
    .clk(clk), .rst_n(rst_n), .cfg_rx(cfg_rx), .cfg_master(cfg_master),
    .cfg_short_addr(cfg_short_addr), .cfg_ack_en(cfg_ack_en), .cfg_hold(cfg_hold),
    .sw_fifo_clr(sw_fifo_clr), .sw_size_wr(sw_size_wr), .sw_size_val(sw_size_val),
    .sw_addr_wr(sw_addr_wr), .sw_addr_val(sw_addr_val), .sw_push(sw_push),
    .sw_wdata(sw_wdata), .sw_pop(sw_pop), .sw_rdata(sw_rdata),
    .size_view(size_view), .rx_data_valid(rx_data_valid), .bus_active(bus_active),
    .evt_done(evt_done), .evt_thresh(evt_thresh), .evt_tx_ovf(evt_tx_ovf),
    .evt_rx_ovf(evt_rx_ovf), .evt_rx_unf(evt_rx_unf), .evt_nack(evt_nack),
    .eng_start(eng_start), .eng_stop(eng_stop), .eng_stretch(eng_stretch),
    .eng_addr(eng_addr), .eng_ten(eng_ten), .eng_read(eng_read),
    .eng_ack_en(eng_ack_en), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid),
    .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready), .eng_nack(eng_nack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int thresh_seen = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] q[$];
  int  m_st;     // 0 idle, 1 running, 2 paused
  int  m_cnt;
  logic [9:0] m_addr;
  bit  m_ten, m_read, m_start, m_stop, m_done, m_nack;
  bit  m_thresh, m_txo, m_rxo, m_unf;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_st = 0; m_cnt = 0; m_addr = '0; m_ten = 0; m_read = 0;
    m_start = 0; m_stop = 0; m_done = 0; m_nack = 0;
    m_thresh = 0; m_txo = 0; m_rxo = 0; m_unf = 0;
  endtask

  // one clock: compare, predict, advance
  task automatic tick();
    int  lvl, nl;
    bit  full, empty, txv, rxr, blk, tx_fire, rx_fire, push, pop, start_req;
    bit  n_start, n_stop, n_done, n_nack;
    int  n_st;
    #1;
    lvl = q.size(); full = (lvl == DEPTH); empty = (lvl == 0);
    txv = (m_st == 1) && !cfg_rx && !empty;
    rxr = (m_st == 1) && cfg_rx && (m_cnt != 0) && !full;
    blk = (m_st == 1) && cfg_rx && (m_cnt != 0) && full;
    chk("R8", "size_view", size_view, cfg_rx ? m_cnt : lvl);
    chk("R12", "rx_data_valid", rx_data_valid, cfg_rx && !empty);
    chk("R12", "bus_active", bus_active, m_st != 0);
    chk("R2", "sw_rdata", sw_rdata, empty ? 8'h00 : q[0]);
    chk("R6", "eng_tx_valid", eng_tx_valid, txv);
    if (txv) chk("R6", "eng_tx_data", eng_tx_data, q[0]);
    chk("R8", "eng_rx_ready", eng_rx_ready, rxr);
    chk("R7", "eng_stretch", eng_stretch, (m_st == 2) || blk);
    chk("R5", "eng_start", eng_start, m_start);
    chk("R5", "eng_addr", eng_addr, m_addr);
    chk("R5", "eng_ten", eng_ten, m_ten);
    chk("R5", "eng_read", eng_read, m_read);
    chk("R6", "eng_stop", eng_stop, m_stop);
    chk("R6", "evt_done", evt_done, m_done);
    chk("R10", "evt_thresh", evt_thresh, m_thresh);
    chk("R3", "evt_tx_ovf", evt_tx_ovf, m_txo);
    chk("R9", "evt_rx_ovf", evt_rx_ovf, m_rxo);
    chk("R4", "evt_rx_unf", evt_rx_unf, m_unf);
    chk("R11", "evt_nack", evt_nack, m_nack);
    if (evt_thresh) thresh_seen++;

    tx_fire = txv && eng_tx_ready;
    rx_fire = rxr && eng_rx_valid;
    push = !sw_fifo_clr && ((sw_push && !cfg_rx && !full) || rx_fire);
    pop  = !sw_fifo_clr && ((sw_pop && cfg_rx && !empty) || tx_fire);
    m_txo = sw_push && !cfg_rx && full;
    m_unf = sw_pop && cfg_rx && empty;
    m_rxo = blk && eng_rx_valid;
    nl = sw_fifo_clr ? 0 : lvl + int'(push) - int'(pop);
    m_thresh = cfg_rx && (lvl < THRESH) && (nl >= THRESH);

    start_req = sw_addr_wr && cfg_master;
    n_st = m_st; n_start = 0; n_stop = 0; n_done = 0; n_nack = 0;
    if (m_st == 0) begin
      if (start_req) begin n_st = 1; n_start = 1; end
    end else if (m_st == 1) begin
      if (eng_nack) begin n_st = 0; n_stop = 1; n_nack = 1; end
      else if (!cfg_rx ? empty : (m_cnt == 0)) begin
        n_done = 1;
        if (cfg_hold) n_st = 2; else begin n_st = 0; n_stop = 1; end
      end
    end else begin
      if (start_req) begin n_st = 1; n_start = 1; end
      else if (!cfg_hold) begin n_st = 0; n_stop = 1; end
      else if (!cfg_rx ? !empty : (m_cnt != 0)) n_st = 1;
    end
    if (n_start) begin
      m_addr = cfg_short_addr ? {3'b000, sw_addr_val[6:0]} : sw_addr_val;
      m_ten  = !cfg_short_addr;
      m_read = cfg_rx;
    end

    if (sw_fifo_clr) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(cfg_rx ? eng_rx_data : sw_wdata);
    end
    if (sw_size_wr) m_cnt = sw_size_val;
    else if (rx_fire && m_cnt != 0) m_cnt = m_cnt - 1;
    m_st = n_st; m_start = n_start; m_stop = n_stop;
    m_done = n_done; m_nack = n_nack;

    @(posedge clk);
    @(negedge clk);
    cycles++;
    eng_rx_data = 8'(cycles * 7 + 3);
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog cycle limit");
      summary();
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic push_byte(input logic [7:0] b);
    sw_push = 1; sw_wdata = b; tick(); sw_push = 0;
  endtask

  task automatic pulse_clr();
    sw_fifo_clr = 1; tick(); sw_fifo_clr = 0;
  endtask

  task automatic write_addr(input logic [9:0] a);
    sw_addr_wr = 1; sw_addr_val = a; tick(); sw_addr_wr = 0;
  endtask

  task automatic load_size(input logic [7:0] n);
    sw_size_wr = 1; sw_size_val = n; tick(); sw_size_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    rst_n = 0;
    cfg_rx = 0; cfg_master = 1; cfg_short_addr = 1; cfg_ack_en = 1; cfg_hold = 0;
    sw_fifo_clr = 0; sw_size_wr = 0; sw_size_val = 0; sw_addr_wr = 0; sw_addr_val = 0;
    sw_push = 0; sw_wdata = 0; sw_pop = 0;
    eng_tx_ready = 0; eng_rx_valid = 0; eng_rx_data = 0; eng_nack = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "bus_active", bus_active, 0);
    chk("R1", "size_view", size_view, 0);
    chk("R1", "events", {evt_done, evt_thresh, evt_tx_ovf, evt_rx_ovf, evt_rx_unf, evt_nack}, 0);
    chk("R1", "start_stop", {eng_start, eng_stop}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R6 transmit with short address, stop at drain
    push_byte(8'hA1); push_byte(8'hB2); push_byte(8'hC3);
    write_addr(10'h3A5);
    chk("R5", "short addr", eng_addr, 10'h025);
    chk("R5", "start pulse", eng_start, 1);
    eng_tx_ready = 1;
    // R2 simultaneous push and engine pop keeps order
    sw_push = 1; sw_wdata = 8'hD4; tick(); sw_push = 0;
    run(6);
    chk("R6", "idle after drain", bus_active, 0);
    eng_tx_ready = 0;

    // R3 overflow, R2 ignored pop in tx, R13 clear
    for (int i = 0; i < 17; i++) push_byte(8'(i + 16));
    chk("R3", "level full", size_view, 16);
    chk("R3", "ovf pulse", evt_tx_ovf, 1);
    sw_pop = 1; tick(); sw_pop = 0;
    chk("R2", "pop ignored in tx", size_view, 16);
    pulse_clr();
    chk("R13", "cleared", size_view, 0);

    // R5 address write ignored without master
    cfg_master = 0; push_byte(8'h55); write_addr(10'h011);
    chk("R5", "no start non-master", bus_active, 0);
    cfg_master = 1;

    // R7 hold in transmit: pause, refill, resume, stop on release
    cfg_hold = 1; eng_tx_ready = 1;
    write_addr(10'h044);
    run(3);
    chk("R7", "paused", bus_active, 1);
    chk("R7", "stretch", eng_stretch, 1);
    push_byte(8'h66);
    run(3);
    cfg_hold = 0; tick();
    chk("R7", "stop on release", eng_stop, 1);
    run(2);
    eng_tx_ready = 0;

    // R11 nack abort
    push_byte(8'h01); push_byte(8'h02);
    write_addr(10'h012);
    eng_nack = 1; tick(); eng_nack = 0;
    chk("R11", "nack event", evt_nack, 1);
    chk("R11", "nack stop", eng_stop, 1);
    run(2);
    pulse_clr();

    // R8/R9/R10 receive with hold, extended address
    cfg_rx = 1; cfg_short_addr = 0; cfg_hold = 1;
    push_byte(8'h77);
    chk("R2", "push ignored in rx", rx_data_valid, 0);
    load_size(8'd20);
    eng_rx_valid = 1;
    write_addr(10'h2C7);
    chk("R5", "ext addr", eng_addr, 10'h2C7);
    chk("R5", "ext flag", eng_ten, 1);
    run(20);
    chk("R9", "rx overflow", evt_rx_ovf, 1);
    chk("R9", "stretch on full", eng_stretch, 1);
    chk("R8", "count left", size_view, 4);
    chk("R10", "one threshold", thresh_seen, 1);
    sw_pop = 1; run(8); sw_pop = 0;
    chk("R7", "rx paused", bus_active, 1);
    load_size(8'd2);
    run(4);
    sw_pop = 1; run(18); sw_pop = 0;
    chk("R4", "underflow", evt_rx_unf, 1);
    chk("R4", "zero read", sw_rdata, 0);
    cfg_hold = 0; tick();
    chk("R7", "rx stop", eng_stop, 1);
    eng_rx_valid = 0;
    run(2);

    // R10 pop collides with arrival at 13: no threshold that cycle
    thresh_seen = 0;
    load_size(8'd40);
    eng_rx_valid = 1;
    write_addr(10'h030);
    run(13);
    sw_pop = 1; run(4); sw_pop = 0;
    chk("R10", "no threshold while popping", thresh_seen, 0);
    run(3);
    chk("R10", "threshold later", thresh_seen, 1);
    eng_nack = 1; tick(); eng_nack = 0;
    eng_rx_valid = 0;
    run(2);
    summary();
  end
endmodule